// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers 8N1 asynchronous serial bytes from a line that is already synchronised to the system clock. An external rate generator supplies a one-cycle sample tick. In normal mode there are 16 ticks per bit, and in fast mode there are 8. The receiver watches the line for a high-to-low step and counts ticks from that point. It settles each bit by a two-of-three majority over the samples around the bit centre.

Completed bytes go into a two-entry queue. Each byte is stored together with its framing-error bit. The host drains the queue with a read strobe while the data-available flag is high.

Dropping the enable stops everything at once. The frame in progress is discarded, the queue is emptied, the overrun flag is cleared and the line is no longer sampled.

Top module: `uart_os_rx`

## Requirements
- R1: With `dbl_speed`=0 a bit lasts 16 sample ticks. With `dbl_speed`=1 it lasts 8 ticks. Clock cycles without `sample_tick` are not samples.
- R2: A frame starts only at a tick where the line is low and the previous tick's sample, taken while enabled, was high. That low sample is sample 1 of the start bit. A line that is already low when the block is enabled does not start a frame.
- R3: Each bit is the majority of its samples 8, 9 and 10 (16x) or 4, 5 and 6 (8x). One wrong sample among them is corrected. Two wrong samples flip the bit.
- R4: If the start-bit vote is high, the frame is abandoned with nothing stored. The receiver then waits for a new falling step.
- R5: A frame is a start bit, 8 data bits sent LSB first, and a stop bit. A high stop bit stores the byte with `rd_ferr`=0.
- R6: A low stop-bit vote stores the byte with `rd_ferr`=1.
- R7: The queue holds 2 bytes. `rx_avail` is high while any byte is unread. A `rd_stb` cycle with data present pops the oldest byte into `rd_data`/`rd_ferr`, and these outputs are valid in the cycle after the strobe.
- R8: A byte that completes while the queue is full (with no pop in that cycle) is dropped and sets `rx_ovr`. `rx_ovr` stays set until a `rd_stb` pops a byte.
- R9: A `rd_stb` while the queue is empty changes nothing: `rd_data` and `rd_ferr` keep their last values.
- R10: With `rx_en`=0 the frame in progress is aborted and the queue is emptied (`rx_avail`=0 the next cycle). `rx_ovr` is cleared and line activity is ignored.
- R11: After reset `rx_avail`, `rx_ovr`, `rd_data` and `rd_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low aborts and flushes |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| sample_tick | input | 1 | One-cycle oversampling strobe |
| rx_line | input | 1 | Synchronised serial input, idle high |
| rd_stb | input | 1 | Pop one byte from the queue |
| rd_data | output | 8 | Last byte popped |
| rd_ferr | output | 1 | Framing error of the last byte popped |
| rx_avail | output | 1 | Unread data present |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
Clean frames are sent in both oversampling modes. This separates a correct bit length from one that drifts, and it shows LSB-first assembly. Frames with one corrupted centre sample and with two corrupted centre samples show that the vote really uses three samples and not one.

A short low pulse, a line held low across enable, and a low stop bit separate false-start rejection, edge qualification and framing-error capture. Three back-to-back frames followed by reads past empty expose the overrun and hold behaviour. Mid-frame disables show the abort and the flush. Random bytes in random modes, each with a single-sample glitch, round out the data path.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_STOP
  } rx_phase_t;

  typedef struct packed {
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler #(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dbl,
  input  logic tick,
  input  logic line,
  input  logic active,
  output logic start_hit,
  output logic vote_hit,
  output logic vote_val
);
  localparam int CW = $clog2(OSR_NORM + 2);

  logic [CW-1:0] cnt, idx, osr, mid;
  logic          prev, v_lo, v_mid;

  generate
    if (OSR_FAST == OSR_NORM) begin : g_fixed_rate
      assign osr = CW'(OSR_NORM);
    end else begin : g_dual_rate
      assign osr = dbl ? CW'(OSR_FAST) : CW'(OSR_NORM);
    end
  endgenerate

  assign mid       = (osr >> 1) + 1'b1;
  assign idx       = cnt + 1'b1;
  assign start_hit = en & tick & ~active & prev & ~line;
  assign vote_hit  = en & tick & active & (idx == mid + 1'b1);
  assign vote_val  = (v_lo & v_mid) | (v_lo & line) | (v_mid & line);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      prev  <= 1'b0;
      v_lo  <= 1'b0;
      v_mid <= 1'b0;
    end else if (tick) begin
      prev <= line;
      if (start_hit) begin
        cnt <= CW'(1);
      end else if (active) begin
        if (idx == mid - 1'b1) v_lo <= line;
        if (idx == mid) v_mid <= line;
        cnt <= (idx == osr) ? '0 : idx;
      end else begin
        cnt <= '0;
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= osr));
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !prev));
endmodule

// File: rtl/uart_os_rx_framer.sv
module uart_os_rx_framer
  import uart_os_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     start_hit,
  input  logic     vote_hit,
  input  logic     vote_val,
  output logic     active,
  output logic     push,
  output rx_word_t push_word
);
  localparam int BW = $clog2(DATA_W);

  rx_phase_t         phase;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;

  assign active = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase     <= PH_IDLE;
      bit_idx   <= '0;
      shreg     <= '0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      push <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_hit) phase <= PH_START;
      end else if (vote_hit) begin
        case (phase)
          PH_START: begin
            if (vote_val) begin
              phase <= PH_IDLE;
            end else begin
              phase   <= PH_DATA;
              bit_idx <= '0;
            end
          end
          PH_DATA: begin
            shreg <= {vote_val, shreg[DATA_W-1:1]};
            if (bit_idx == BW'(DATA_W - 1)) phase <= PH_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end
          default: begin
            push           <= 1'b1;
            push_word.data <= shreg;
            push_word.ferr <= ~vote_val;
            phase          <= PH_IDLE;
          end
        endcase
      end
    end
  end

  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == PH_IDLE && !push));
  assert_false_start_R4: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_START && vote_hit && vote_val) |=> (phase == PH_IDLE && !push));
endmodule

// File: rtl/uart_os_rx_fifo.sv
module uart_os_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop_req,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          pop, space, wr;

  assign not_empty = (count != '0);
  assign pop       = pop_req && not_empty && !flush;
  assign space     = (count < CW'(DEPTH)) || pop;
  assign wr        = push && space && !flush;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) ovr <= 1'b0;
    else if (push && !space) ovr <= 1'b1;
    else if (pop) ovr <= 1'b0;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (rst)
    (push && !flush && count == CW'(DEPTH) && !pop_req) |=> ovr);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !not_empty) |=> $stable(rdata));
  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!not_empty && !ovr));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8,
  parameter int DEPTH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              dbl_speed,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rx_avail,
  output logic              rx_ovr
);
  localparam int WW = $bits(rx_word_t);

  logic     start_hit, vote_hit, vote_val, active, push;
  rx_word_t push_word, head_word;

  uart_os_rx_sampler #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) sampler_i (
    .clk(clk), .rst(rst), .en(rx_en), .dbl(dbl_speed), .tick(sample_tick),
    .line(rx_line), .active(active), .start_hit(start_hit),
    .vote_hit(vote_hit), .vote_val(vote_val)
  );

  uart_os_rx_framer framer_i (
    .clk(clk), .rst(rst), .en(rx_en), .start_hit(start_hit),
    .vote_hit(vote_hit), .vote_val(vote_val), .active(active),
    .push(push), .push_word(push_word)
  );

  uart_os_rx_fifo #(.DEPTH(DEPTH), .W(WW)) fifo_i (
    .clk(clk), .rst(rst), .flush(!rx_en), .push(push), .wdata(push_word),
    .pop_req(rd_stb), .rdata(head_word), .not_empty(rx_avail), .ovr(rx_ovr)
  );

  assign rd_data = head_word.data;
  assign rd_ferr = head_word.ferr;

  assert_disable_flush_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_avail && !rx_ovr));
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ferr, rx_avail, rx_ovr;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  uart_os_rx dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .dbl_speed(dbl_speed),
    .sample_tick(sample_tick), .rx_line(rx_line), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .rx_avail(rx_avail), .rx_ovr(rx_ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int osr_now();
    return dbl_speed ? 8 : 16;
  endfunction

  function automatic bit in_centre(input int pos);
    int m = osr_now() / 2 + 1;
    return (pos >= m - 1) && (pos <= m + 1);
  endfunction

  // Expected byte after glitches: a data bit flips only if two centre samples are hit.
  function automatic logic [7:0] expect_byte(input logic [7:0] d, input int fb,
                                             input int fp1, input int fp2);
    int n = 0;
    logic [7:0] r = d;
    if (fp1 != 0 && in_centre(fp1)) n++;
    if (fp2 != 0 && fp2 != fp1 && in_centre(fp2)) n++;
    if (fb >= 1 && fb <= 8 && n >= 2) r[fb-1] = ~r[fb-1];
    return r;
  endfunction

  task automatic samp(input logic b);
    @(negedge clk);
    rx_line = b;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) samp(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_b,
                            input int fb, input int fp1, input int fp2);
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = (i == 0) ? 1'b0 : (i == 9) ? stop_b : d[i-1];
      for (int s = 1; s <= osr_now(); s++) begin
        logic v;
        v = b;
        if (i == fb && (s == fp1 || s == fp2)) v = ~v;
        samp(v);
      end
    end
    idle(3);
  endtask

  task automatic rd(output logic [7:0] d, output logic f);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
    f = rd_ferr;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       f;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 avail", rx_avail, 0);
    check("R11 ovr", rx_ovr, 0);
    check("R11 data", rd_data, 0);
    check("R11 ferr", rd_ferr, 0);

    rx_en = 1'b1;
    idle(4);
    // R5 basic 16x frame
    send_frame(8'hA5, 1'b1, 0, 0, 0);
    check("R7 avail after frame", rx_avail, 1);
    rd(d, f);
    check("R5 data 16x", d, 8'hA5);
    check("R5 ferr clear", f, 0);
    check("R7 avail after pop", rx_avail, 0);

    // R1 fast mode
    dbl_speed = 1'b1;
    idle(4);
    send_frame(8'h3C, 1'b1, 0, 0, 0);
    rd(d, f);
    check("R1 data 8x", d, 8'h3C);

    // R3 single and double centre glitches, both modes
    send_frame(8'h96, 1'b1, 3, 5, 0);
    rd(d, f);
    check("R3 single glitch 8x", d, expect_byte(8'h96, 3, 5, 0));
    dbl_speed = 1'b0;
    idle(4);
    send_frame(8'h0F, 1'b1, 2, 9, 0);
    rd(d, f);
    check("R3 single glitch 16x", d, expect_byte(8'h0F, 2, 9, 0));
    send_frame(8'h0F, 1'b1, 2, 8, 10);
    rd(d, f);
    check("R3 double glitch 16x", d, expect_byte(8'h0F, 2, 8, 10));

    // R4 false start: short low pulse
    samp(1'b0); samp(1'b0); samp(1'b0);
    idle(40);
    check("R4 no byte after glitch", rx_avail, 0);
    send_frame(8'h81, 1'b1, 0, 0, 0);
    rd(d, f);
    check("R4 next frame ok", d, 8'h81);

    // R6 framing error
    send_frame(8'h55, 1'b0, 0, 0, 0);
    idle(20);
    rd(d, f);
    check("R6 data", d, 8'h55);
    check("R6 ferr set", f, 1);

    // R8 overrun and R9 empty read
    send_frame(8'h11, 1'b1, 0, 0, 0);
    send_frame(8'h22, 1'b1, 0, 0, 0);
    check("R8 no ovr when full", rx_ovr, 0);
    send_frame(8'h33, 1'b1, 0, 0, 0);
    check("R8 ovr set", rx_ovr, 1);
    rd(d, f);
    check("R8 oldest kept", d, 8'h11);
    check("R8 ovr cleared by read", rx_ovr, 0);
    rd(d, f);
    check("R8 second kept", d, 8'h22);
    check("R7 empty after two", rx_avail, 0);
    rd(d, f);
    check("R9 empty read holds data", d, 8'h22);
    check("R9 empty read holds ferr", f, 0);

    // R10 flush
    send_frame(8'h44, 1'b1, 0, 0, 0);
    send_frame(8'h66, 1'b1, 0, 0, 0);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    check("R10 flushed", rx_avail, 0);
    rx_en = 1'b1;
    rd(d, f);
    check("R10 flushed read holds", d, 8'h22);

    // R10 abort mid frame, activity while off ignored
    idle(4);
    for (int i = 0; i < 16 * 4; i++) samp(i < 16 ? 1'b0 : 1'b1);
    rx_en = 1'b0;
    for (int i = 0; i < 16 * 10; i++) samp(i[4]);
    rx_en = 1'b1;
    idle(4);
    send_frame(8'h5A, 1'b1, 0, 0, 0);
    rd(d, f);
    check("R10 fresh frame after abort", d, 8'h5A);
    check("R10 only one byte", rx_avail, 0);

    // R2 line low at enable
    rx_en = 1'b0;
    samp(1'b0); samp(1'b0);
    rx_en = 1'b1;
    for (int i = 0; i < 200; i++) samp(1'b0);
    idle(20);
    check("R2 low at enable not a start", rx_avail, 0);

    // random frames with a single glitch
    for (int k = 0; k < 20; k++) begin
      logic [7:0] v;
      int fb, fp;
      dbl_speed = $urandom_range(0, 1);
      idle(4);
      v  = 8'($urandom);
      fb = $urandom_range(1, 8);
      fp = $urandom_range(1, osr_now());
      send_frame(v, 1'b1, fb, fp, 0);
      rd(d, f);
      check("R3 random glitch data", d, expect_byte(v, fb, fp, 0));
      check("R5 random ferr", f, 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule